// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block runs a multi-register load or store. A single start pulse brings in a 16-bit register-select mask, a base address, one of four addressing rules, the transfer direction and two option flags. The sequencer counts the selected registers and works out the first address. It then makes one 32-bit memory access for each selected register, lowest register first. Each access goes through a valid/ready memory request port. On a load the returned word is written into the register file through a write port. On a store the register is read through a combinational read port and its value is sent to memory.

Register 15 acts as the program counter. When a load includes it, bit 0 of the loaded word selects the instruction-set state. That bit is cleared before the word is written. A load that includes register 15 and has the status-restore flag set also issues a one-cycle command to copy the saved status register into the current one. When write-back is enabled, the sequencer gives the address that follows the final access as the new base value. This is shown in the cycle in which it signals completion.

Top module: `blk_xfer_seq`

## Requirements
- R1: Addressing mode code 0 (ascending, access then step) makes the first access at the base address.
- R2: Mode code 1 (ascending, step then access) makes the first access at base + 4.
- R3: Mode code 2 (descending, access then step) makes the first access at base − 4·N + 4, where N is the number of set bits in the mask.
- R4: Mode code 3 (descending, step then access) makes the first access at base − 4·N.
- R5: Accesses go in ascending register index order, one per set mask bit. Each address is 4 above the one before it. A request holds its address and register index until mem_ready_i is high.
- R6: With wback_i set, base_we_o is high in the done_o cycle and base_wdata_o carries first address + 4·N. With wback_i clear, base_we_o stays low.
- R7: On a load that writes register 15, the value written has bit 0 cleared. isa_we_o pulses with isa_alt_o equal to bit 0 of the loaded word.
- R8: psr_copy_o pulses in the done_o cycle only for a load with psr_rest_i set and mask bit 15 set. It never pulses for a store.
- R9: An empty mask makes no memory access. done_o is high in the cycle after start is sampled, and a write-back carries the unchanged base.
- R10: done_o is high for exactly one cycle per operation. A start_i pulse while busy_o is high is ignored.
- R11: A store sends the value on reg_rdata_i for the current reg_idx_o to memory. A load writes mem_rdata_i into the register at reg_idx_o in the accepted cycle.
- R12: After reset the block is idle: busy_o, done_o, mem_req_o and reg_we_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (sampled only when idle) |
| load_i | input | 1 | 1 = load from memory, 0 = store to memory |
| mode_i | input | 2 | Addressing rule code 0..3 |
| list_i | input | 16 | Register-select mask, bit i = register i |
| base_i | input | 32 | Base address |
| wback_i | input | 1 | Request base write-back |
| psr_rest_i | input | 1 | Restore status when register 15 is loaded |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_rdata_i | input | 32 | Memory read data, valid with mem_ready_i |
| reg_idx_o | output | 4 | Register file index for the current access |
| reg_we_o | output | 1 | Register file write strobe |
| reg_wdata_o | output | 32 | Register file write data |
| reg_rdata_i | input | 32 | Register file read data for reg_idx_o |
| isa_we_o | output | 1 | Instruction-set state update strobe |
| isa_alt_o | output | 1 | New instruction-set state |
| base_we_o | output | 1 | Base write-back strobe |
| base_wdata_o | output | 32 | Base write-back value |
| psr_copy_o | output | 1 | Copy saved status into current status |

## Verification
The hardest case to reach from the ports is a second start pulse that arrives mid-transfer. If the engine restarted, it would corrupt the register walk without any visible error. The bench stretches a two-register load with alternating memory stalls so the engine stays busy. It then drives a full-mask start pulse in that window. Afterwards it checks that exactly two accesses and a single done pulse occurred and that the engine settles idle. The register-15 path is reached by placing an odd word and an even word at the addresses the descending and ascending rules select, so that the state bit, the cleared PC bit and the status-restore pulse can each be seen at the ports.

// File: rtl/bxs_pkg.sv
package bxs_pkg;

  // Addressing rule codes; the numeric values are decoded at the port.
  typedef enum logic [1:0] {
    AM_UP_AFTER   = 2'd0,
    AM_UP_BEFORE  = 2'd1,
    AM_DN_AFTER   = 2'd2,
    AM_DN_BEFORE  = 2'd3
  } addr_rule_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_XFER = 2'd1,
    SQ_FIN  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/bxs_span.sv
// Counts selected registers and derives the first address and the
// address following the last access for one of four addressing rules.
module bxs_span
  import bxs_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int ADDR_W = 32,
  parameter int STEP   = 4,
  parameter int CNT_W  = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0]   list_i,
  input  addr_rule_e        rule_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [ADDR_W-1:0] first_o,
  output logic [ADDR_W-1:0] after_o
);

  localparam int SH = $clog2(STEP);

  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] span;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++) begin
      cnt = cnt + CNT_W'(list_i[i]);
    end
  end

  assign span = ADDR_W'(cnt) << SH;

  always_comb begin
    unique case (rule_i)
      AM_UP_AFTER:  first_o = base_i;
      AM_UP_BEFORE: first_o = base_i + ADDR_W'(STEP);
      AM_DN_AFTER:  first_o = base_i - span + ADDR_W'(STEP);
      default:      first_o = base_i - span;
    endcase
  end

  assign after_o = (cnt == '0) ? base_i : (first_o + span);
  assign count_o = cnt;

endmodule

// File: rtl/bxs_pick.sv
// Selects the lowest pending register of the mask.
module bxs_pick #(
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]  pend_i,
  output logic [NREG-1:0]  low_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);

  logic [IDX_W-1:0] term [NREG];

  assign low_o = pend_i & (~pend_i + NREG'(1));
  assign any_o = |pend_i;

  for (genvar g = 0; g < NREG; g++) begin : g_term
    assign term[g] = low_o[g] ? IDX_W'(g) : '0;
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NREG; i++) begin
      idx_o = idx_o | term[i];
    end
  end

endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import bxs_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int STEP   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     load_i,
  input  logic [1:0]               mode_i,
  input  logic [NREG-1:0]          list_i,
  input  logic [ADDR_W-1:0]        base_i,
  input  logic                     wback_i,
  input  logic                     psr_rest_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     mem_req_o,
  output logic                     mem_we_o,
  output logic [ADDR_W-1:0]        mem_addr_o,
  output logic [DATA_W-1:0]        mem_wdata_o,
  input  logic                     mem_ready_i,
  input  logic [DATA_W-1:0]        mem_rdata_i,
  output logic [$clog2(NREG)-1:0]  reg_idx_o,
  output logic                     reg_we_o,
  output logic [DATA_W-1:0]        reg_wdata_o,
  input  logic [DATA_W-1:0]        reg_rdata_i,
  output logic                     isa_we_o,
  output logic                     isa_alt_o,
  output logic                     base_we_o,
  output logic [ADDR_W-1:0]        base_wdata_o,
  output logic                     psr_copy_o
);

  localparam int IDX_W = $clog2(NREG);
  localparam int CNT_W = $clog2(NREG + 1);
  localparam logic [IDX_W-1:0] PC_IDX = IDX_W'(NREG - 1);

  // State and captured operation
  seq_state_e        st_q, st_d;
  logic [NREG-1:0]   pend_q, pend_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] wbv_q;
  logic              ld_q, wb_q, rest_q, pc_q;

  logic              cap_en, step_en;

  // Start-address computation from the live inputs
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] first_addr, after_addr;

  bxs_span #(
    .NREG(NREG), .ADDR_W(ADDR_W), .STEP(STEP), .CNT_W(CNT_W)
  ) u_span (
    .list_i  (list_i),
    .rule_i  (addr_rule_e'(mode_i)),
    .base_i  (base_i),
    .count_o (cnt),
    .first_o (first_addr),
    .after_o (after_addr)
  );

  // Lowest pending register
  logic [NREG-1:0]  low;
  logic [IDX_W-1:0] cur_idx;
  logic             pend_any;

  bxs_pick #(.NREG(NREG), .IDX_W(IDX_W)) u_pick (
    .pend_i (pend_q),
    .low_o  (low),
    .idx_o  (cur_idx),
    .any_o  (pend_any)
  );

  logic fire;
  logic [NREG-1:0] pend_left;

  assign fire      = (st_q == SQ_XFER) && mem_ready_i && pend_any;
  assign pend_left = pend_q & ~low;

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    pend_d  = pend_q;
    addr_d  = addr_q;
    cap_en  = 1'b0;
    step_en = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (start_i) begin
          cap_en = 1'b1;
          pend_d = list_i;
          addr_d = first_addr;
          st_d   = (cnt == '0) ? SQ_FIN : SQ_XFER;
        end
      end
      SQ_XFER: begin
        if (fire) begin
          step_en = 1'b1;
          pend_d  = pend_left;
          addr_d  = addr_q + ADDR_W'(STEP);
          if (pend_left == '0) st_d = SQ_FIN;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      addr_q <= '0;
    end else if (cap_en || step_en) begin
      pend_q <= pend_d;
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbv_q  <= '0;
      ld_q   <= 1'b0;
      wb_q   <= 1'b0;
      rest_q <= 1'b0;
      pc_q   <= 1'b0;
    end else if (cap_en) begin
      wbv_q  <= after_addr;
      ld_q   <= load_i;
      wb_q   <= wback_i;
      rest_q <= psr_rest_i;
      pc_q   <= list_i[NREG-1];
    end
  end

  // Outputs
  logic in_fin;
  logic pc_hit;

  assign in_fin = (st_q == SQ_FIN);
  assign pc_hit = (cur_idx == PC_IDX);

  assign busy_o       = (st_q != SQ_IDLE);
  assign done_o       = in_fin;
  assign mem_req_o    = (st_q == SQ_XFER);
  assign mem_we_o     = mem_req_o && !ld_q;
  assign mem_addr_o   = addr_q;
  assign mem_wdata_o  = reg_rdata_i;
  assign reg_idx_o    = cur_idx;
  assign reg_we_o     = fire && ld_q;
  assign reg_wdata_o  = pc_hit ? {mem_rdata_i[DATA_W-1:1], 1'b0} : mem_rdata_i;
  assign isa_we_o     = reg_we_o && pc_hit;
  assign isa_alt_o    = mem_rdata_i[0];
  assign base_we_o    = in_fin && wb_q;
  assign base_wdata_o = wbv_q;
  assign psr_copy_o   = in_fin && ld_q && rest_q && pc_q;

endmodule

// File: rtl/bxs_chk.sv
module bxs_chk #(
  parameter int NREG   = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int STEP   = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    busy_o,
  input logic                    done_o,
  input logic                    mem_req_o,
  input logic                    mem_ready_i,
  input logic [ADDR_W-1:0]       mem_addr_o,
  input logic [$clog2(NREG)-1:0] reg_idx_o,
  input logic                    reg_we_o,
  input logic [DATA_W-1:0]       reg_wdata_o,
  input logic                    base_we_o,
  input logic                    psr_copy_o,
  input logic                    mem_we_o
);

  localparam logic [$clog2(NREG)-1:0] PC_IDX = $clog2(NREG)'(NREG - 1);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(reg_idx_o))); // R5

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_ready_i) |=> (!mem_req_o || (mem_addr_o == $past(mem_addr_o) + ADDR_W'(STEP)))); // R5

  AST_IDX_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_ready_i) |=> (!mem_req_o || (reg_idx_o > $past(reg_idx_o)))); // R5

  AST_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_o && reg_idx_o == PC_IDX) |-> !reg_wdata_o[0]); // R7

  AST_BASE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    base_we_o |-> done_o); // R6

  AST_PSR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    psr_copy_o |-> done_o); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_req_o && !reg_we_o && !mem_we_o)); // R12

endmodule

bind blk_xfer_seq bxs_chk #(
  .NREG(NREG), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP(STEP)
) u_bxs_chk (.*);

// File: tb/tb_blk_xfer_seq.sv
`timescale 1ns/1ps
module tb_blk_xfer_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, load_i, wback_i, psr_rest_i;
  logic [1:0]  mode_i;
  logic [15:0] list_i;
  logic [31:0] base_i;
  logic        busy_o, done_o, mem_req_o, mem_we_o, mem_ready_i;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic [3:0]  reg_idx_o;
  logic        reg_we_o;
  logic [31:0] reg_wdata_o, reg_rdata_i;
  logic        isa_we_o, isa_alt_o, base_we_o, psr_copy_o;
  logic [31:0] base_wdata_o;

  always #4 clk = ~clk;

  blk_xfer_seq dut (.*);

  // Memory and register file models
  logic [31:0] mem [64];
  logic [31:0] rf  [16];
  assign mem_rdata_i = mem[mem_addr_o[7:2]];
  assign reg_rdata_i = rf[reg_idx_o];

  function automatic logic [31:0] rf_init(int i);
    return 32'h1000_0000 + 32'(i) * 32'h0101;
  endfunction
  function automatic logic [31:0] mem_init(int w);
    return 32'hC000_0000 + 32'(w) * 32'h10 + ((w == 31) ? 32'd1 : 32'd0);
  endfunction

  // Monitor state
  logic        init_req;
  int          cyc, n_acc, n_done, start_cyc, done_cyc;
  logic [31:0] log_addr [32];
  logic [3:0]  log_idx  [32];
  logic        isa_seen, isa_val, wb_seen, psr_seen;
  logic [31:0] wb_val;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (init_req) begin
      for (int i = 0; i < 64; i++) mem[i] <= mem_init(i);
      for (int i = 0; i < 16; i++) rf[i]  <= rf_init(i);
      n_acc <= 0; n_done <= 0; isa_seen <= 1'b0; wb_seen <= 1'b0;
      psr_seen <= 1'b0; wb_val <= '0;
    end else begin
      if (mem_req_o && mem_ready_i) begin
        if (n_acc < 32) begin
          log_addr[n_acc] <= mem_addr_o;
          log_idx[n_acc]  <= reg_idx_o;
        end
        n_acc <= n_acc + 1;
        if (mem_we_o) mem[mem_addr_o[7:2]] <= mem_wdata_o;
      end
      if (reg_we_o) rf[reg_idx_o] <= reg_wdata_o;
      if (isa_we_o) begin isa_seen <= 1'b1; isa_val <= isa_alt_o; end
      if (done_o) begin n_done <= n_done + 1; done_cyc <= cyc; end
      if (base_we_o) begin wb_seen <= 1'b1; wb_val <= base_wdata_o; end
      if (psr_copy_o) psr_seen <= 1'b1;
      if (start_i && !busy_o) start_cyc <= cyc;
    end
  end

  // Stall generator
  logic stall_en = 1'b0;
  logic rdy_tog  = 1'b0;
  always @(negedge clk) rdy_tog <= ~rdy_tog;
  assign mem_ready_i = !stall_en || rdy_tog;

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic reinit();
    @(negedge clk); init_req = 1'b1;
    @(negedge clk); init_req = 1'b0;
  endtask

  // Issue one operation and wait for completion
  task automatic run_op(input bit ld, input logic [1:0] md, input logic [31:0] base,
                        input logic [15:0] lst, input bit wb, input bit rs,
                        input bit poke);
    int t;
    reinit();
    load_i = ld; mode_i = md; base_i = base; list_i = lst;
    wback_i = wb; psr_rest_i = rs; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; list_i = '0;
    if (poke) begin
      @(negedge clk);
      start_i = 1'b1; list_i = 16'hFFFF; mode_i = 2'd3;
      @(negedge clk);
      start_i = 1'b0; list_i = '0;
    end
    t = 0;
    while (n_done == 0 && t < 200) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
  endtask

  // Compare the access log against the expected walk
  task automatic chk_walk(input logic [31:0] first, input logic [15:0] lst, input string tag);
    int k;
    k = 0;
    chk(n_acc == $countones(lst), {tag, " access count"}, 32'(n_acc), 32'($countones(lst)));
    for (int i = 0; i < 16; i++) begin
      if (lst[i] && k < n_acc) begin
        chk(log_addr[k] == first + 32'(k) * 32'd4, {tag, " address"}, log_addr[k], first + 32'(k) * 32'd4);
        chk(log_idx[k] == 4'(i), {"R5 register order ", tag}, 32'(log_idx[k]), 32'(i));
        k++;
      end
    end
  endtask

  task automatic t_reset();
    chk(!busy_o && !done_o, "R12 busy/done after reset", {30'd0, busy_o, done_o}, 32'd0);
    chk(!mem_req_o && !reg_we_o, "R12 request/write after reset", {30'd0, mem_req_o, reg_we_o}, 32'd0);
  endtask

  task automatic t_store_up_after();
    stall_en = 1'b0;
    run_op(1'b0, 2'd0, 32'h40, 16'h00A5, 1'b1, 1'b0, 1'b0);
    chk_walk(32'h40, 16'h00A5, "R1");
    chk(mem[16] == rf_init(0) && mem[17] == rf_init(2), "R11 store data", mem[17], rf_init(2));
    chk(mem[18] == rf_init(5) && mem[19] == rf_init(7), "R11 store data high", mem[19], rf_init(7));
    chk(wb_seen && wb_val == 32'h50, "R6 writeback", wb_val, 32'h50);
    chk(n_done == 1, "R10 one done", 32'(n_done), 32'd1);
  endtask

  task automatic t_load_up_before();
    stall_en = 1'b1;
    run_op(1'b1, 2'd1, 32'h20, 16'h0F0F, 1'b0, 1'b0, 1'b0);
    stall_en = 1'b0;
    chk_walk(32'h24, 16'h0F0F, "R2");
    chk(rf[0] == mem_init(9) && rf[3] == mem_init(12), "R11 load low", rf[3], mem_init(12));
    chk(rf[8] == mem_init(13) && rf[11] == mem_init(16), "R11 load high", rf[11], mem_init(16));
    chk(rf[4] == rf_init(4), "R11 unselected kept", rf[4], rf_init(4));
    chk(!wb_seen, "R6 no writeback when disabled", {31'd0, wb_seen}, 32'd0);
  endtask

  task automatic t_store_down_after();
    stall_en = 1'b0;
    run_op(1'b0, 2'd2, 32'h80, 16'h8001, 1'b1, 1'b1, 1'b0);
    chk_walk(32'h7C, 16'h8001, "R3");
    chk(mem[31] == rf_init(0) && mem[32] == rf_init(15), "R11 store incl. r15", mem[32], rf_init(15));
    chk(wb_val == 32'h84, "R6 writeback past last", wb_val, 32'h84);
    chk(!psr_seen && !isa_seen, "R8 no status copy on store", {30'd0, psr_seen, isa_seen}, 32'd0);
  endtask

  task automatic t_load_down_before_pc();
    stall_en = 1'b1;
    run_op(1'b1, 2'd3, 32'h80, 16'h8003, 1'b1, 1'b1, 1'b0);
    stall_en = 1'b0;
    chk_walk(32'h74, 16'h8003, "R4");
    chk(rf[15] == (mem_init(31) & ~32'd1), "R7 pc bit0 cleared", rf[15], mem_init(31) & ~32'd1);
    chk(isa_seen && isa_val, "R7 state from odd word", {30'd0, isa_seen, isa_val}, 32'd3);
    chk(psr_seen, "R8 status copy", {31'd0, psr_seen}, 32'd1);
    chk(wb_val == 32'h80, "R6 writeback descending", wb_val, 32'h80);
  endtask

  task automatic t_load_pc_even();
    run_op(1'b1, 2'd0, 32'h78, 16'h8000, 1'b0, 1'b0, 1'b0);
    chk(rf[15] == mem_init(30), "R7 pc even value", rf[15], mem_init(30));
    chk(isa_seen && !isa_val, "R7 state from even word", {30'd0, isa_seen, isa_val}, 32'd2);
    chk(!psr_seen, "R8 no copy without flag", {31'd0, psr_seen}, 32'd0);
  endtask

  task automatic t_load_flag_no_pc();
    run_op(1'b1, 2'd0, 32'h10, 16'h0010, 1'b0, 1'b1, 1'b0);
    chk(!psr_seen && !isa_seen, "R8 no copy without r15", {30'd0, psr_seen, isa_seen}, 32'd0);
    chk(rf[4] == mem_init(4), "R11 single load", rf[4], mem_init(4));
  endtask

  task automatic t_empty();
    run_op(1'b1, 2'd1, 32'h30, 16'h0000, 1'b1, 1'b1, 1'b0);
    chk(n_acc == 0, "R9 no access", 32'(n_acc), 32'd0);
    chk(done_cyc - start_cyc == 1, "R9 done next cycle", 32'(done_cyc - start_cyc), 32'd1);
    chk(wb_seen && wb_val == 32'h30, "R9 base unchanged", wb_val, 32'h30);
  endtask

  task automatic t_busy_ignore();
    stall_en = 1'b1;
    run_op(1'b1, 2'd0, 32'h00, 16'h0006, 1'b0, 1'b0, 1'b1);
    stall_en = 1'b0;
    chk(n_acc == 2, "R10 start ignored while busy", 32'(n_acc), 32'd2);
    chk(n_done == 1, "R10 single done pulse", 32'(n_done), 32'd1);
    chk(!busy_o, "R10 idle after op", {31'd0, busy_o}, 32'd0);
    chk(rf[1] == mem_init(0) && rf[2] == mem_init(1), "R11 loads under stall", rf[2], mem_init(1));
  endtask

  initial begin
    #1_000_000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; load_i = 1'b0; mode_i = '0; list_i = '0;
    base_i = '0; wback_i = 1'b0; psr_rest_i = 1'b0; init_req = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    init_req = 1'b0;
    t_reset();
    t_store_up_after();
    t_load_up_before();
    t_store_down_after();
    t_load_down_before_pc();
    t_load_pc_even();
    t_load_flag_no_pc();
    t_empty();
    t_busy_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule